// File: doc/BRIEF.md
# Two-Pass Program Counter Stepper

This block holds a 16-bit program address and advances it using a single 8-bit adder that is also the data adder of a small 8-bit datapath. A step adds either one or an 8-bit offset to the address. The offset can be read as unsigned or as two's complement. The low byte is always summed in the cycle the step is accepted. When that sum leaves the high byte untouched, the update is complete in that one cycle. When the high byte must change, a second pass through the same adder applies a stored carry code to the high byte. The code means either "add one" or "add all-ones", which subtracts one.

The block also contains the datapath result selector. A 2-bit code picks one of four results: the shared adder's sum, a bitwise AND/OR, a one-place logical shift, or operand B passed straight through. The adder can serve only one user per cycle. Whenever the counter holds it, the add result reads as zero. A load input overwrites the address in one cycle and overrides any step or pending second pass.

The control is a two-state machine. ST_READY accepts loads and steps. On a step whose high-byte adjustment is nonzero, it takes transition T_NEED_HIGH to ST_HIGH. ST_HIGH returns to ST_READY after one cycle, either by T_HIGH_DONE (the high-byte pass finishes) or by T_HIGH_LOAD (a load overrides it). All other cycles keep ST_READY through T_STAY.

Top module: `pc_stepper`

## Requirements
- R1: After reset the address is 0x0000, `busy` is 0 and the machine is in ST_READY.
- R2: In ST_READY, a step (`step_en`=1, `load_en`=0) adds 1 when `use_off`=0, or adds `offset` when `use_off`=1. The offset is zero-extended when `off_signed`=0 and sign-extended when `off_signed`=1.
- R3: If the step's high-byte adjustment is zero, the new address appears after one clock edge and `busy` stays 0. A zero adjustment means no carry for a non-negative addend, or a carry for a negative addend.
- R4: Otherwise, after the first edge the low byte is updated, the high byte is unchanged and `busy` is 1. After the second edge the high byte has moved by +1 or −1 modulo 256 and `busy` is 0.
- R5: `busy` is never high for two consecutive cycles, and steps presented while `busy` is 1 are ignored.
- R6: `load_en`=1 writes `load_addr` to the address at the next edge and leaves `busy` 0. This holds both in ST_READY and in ST_HIGH, and load wins over `step_en`.
- R7: With neither a load, a step nor a pending pass, the address holds its value.
- R8: `alu_sel` 2'b00 gives `op_a+op_b`, with the carry out on `alu_co`, when the counter does not hold the adder. While `busy` is 1 or a step is accepted, this result and `alu_co` read 0.
- R9: `alu_sel` 2'b01 gives `op_a|op_b` when `logic_or`=1 and `op_a&op_b` when `logic_or`=0. 2'b10 gives `op_a` shifted one place, left when `shift_right`=0 and right when it is 1, with zero fill. 2'b11 gives `op_b`. `alu_co` is 0 for all three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | Request an address step |
| use_off | input | 1 | 1: add offset, 0: add one |
| off_signed | input | 1 | Treat offset as two's complement |
| offset | input | 8 | Step offset |
| load_en | input | 1 | Load address (priority) |
| load_addr | input | 16 | Value to load |
| alu_sel | input | 2 | Result source select |
| op_a | input | 8 | Datapath operand A |
| op_b | input | 8 | Datapath operand B |
| logic_or | input | 1 | 1: OR, 0: AND for code 01 |
| shift_right | input | 1 | Shift direction for code 10 |
| pc | output | 16 | Current address |
| busy | output | 1 | High-byte pass in progress |
| alu_y | output | 8 | Selected datapath result |
| alu_co | output | 1 | Adder carry for code 00 |

## Verification
The bench builds the block with its default byte width of 8 bits, so the address is 16 bits. At that width, both wrap cases are reachable within a few cycles through the load path: 0xFFFF stepping to 0x0000, and 0x0000 stepping backwards to 0xFFFF. Offsets are chosen so that every combination of carry and addend sign occurs. Between them they cover the one-pass case, the forward two-pass case and the backward two-pass case. Loads and steps are applied in the middle of a second pass, which covers the override and the ignore behaviour.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
    typedef enum logic {
        ST_READY = 1'b0,
        ST_HIGH  = 1'b1
    } pcs_state_e;

    typedef enum logic [1:0] {
        CC_NONE = 2'b00,
        CC_INC  = 2'b01,
        CC_DEC  = 2'b10
    } pcs_carry_e;

    typedef enum logic [1:0] {
        SEL_ADD   = 2'b00,
        SEL_LOGIC = 2'b01,
        SEL_SHIFT = 2'b10,
        SEL_PASSB = 2'b11
    } pcs_sel_e;
endpackage

// File: rtl/pcs_adder.sv
module pcs_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W:0] chain;

    assign chain[0] = cin;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum[i]     = a[i] ^ b[i] ^ chain[i];
        assign chain[i+1] = (a[i] & b[i]) | (chain[i] & (a[i] ^ b[i]));
    end

    assign cout = chain[W];
endmodule

// File: rtl/pcs_result_mux.sv
module pcs_result_mux
    import pcs_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [1:0]   sel,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         logic_or,
    input  logic         shift_right,
    input  logic [W-1:0] add_sum,
    input  logic         add_cout,
    input  logic         add_free,
    output logic [W-1:0] y,
    output logic         co
);
    logic [W-1:0] logic_res;
    logic [W-1:0] shift_res;

    always_comb begin
        logic_res = logic_or ? (op_a | op_b) : (op_a & op_b);
        shift_res = shift_right ? {1'b0, op_a[W-1:1]} : {op_a[W-2:0], 1'b0};
    end

    always_comb begin
        y  = '0;
        co = 1'b0;
        unique case (pcs_sel_e'(sel))
            SEL_ADD: begin
                if (add_free) begin
                    y  = add_sum;
                    co = add_cout;
                end
            end
            SEL_LOGIC: y = logic_res;
            SEL_SHIFT: y = shift_res;
            SEL_PASSB: y = op_b;
        endcase
    end
endmodule

// File: rtl/pcs_pc_fsm.sv
module pcs_pc_fsm
    import pcs_pkg::*;
#(
    parameter int W = 8,
    localparam int AW = 2 * W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_en,
    input  logic          use_off,
    input  logic          off_signed,
    input  logic [W-1:0]  offset,
    input  logic          load_en,
    input  logic [AW-1:0] load_addr,
    input  logic [W-1:0]  op_a,
    input  logic [W-1:0]  op_b,
    input  logic [W-1:0]  add_sum,
    input  logic          add_cout,
    output logic [W-1:0]  add_a,
    output logic [W-1:0]  add_b,
    output logic          add_cin,
    output logic          add_free,
    output logic [AW-1:0] pc,
    output logic          busy
);
    pcs_state_e    state_q, state_d;
    pcs_carry_e    cc_q, cc_d;
    logic [AW-1:0] pc_q, pc_d;
    logic          step_go;
    logic          addend_neg;
    logic [W-1:0]  addend;

    always_comb begin
        step_go    = (state_q == ST_READY) && step_en && !load_en;
        addend     = use_off ? offset : W'(1);
        addend_neg = use_off && off_signed && offset[W-1];
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_READY;
            cc_q    <= CC_NONE;
            pc_q    <= '0;
        end else begin
            state_q <= state_d;
            cc_q    <= cc_d;
            pc_q    <= pc_d;
        end
    end

    // next state and address
    always_comb begin
        state_d = state_q;
        cc_d    = cc_q;
        pc_d    = pc_q;
        unique case (state_q)
            ST_READY: begin
                if (load_en) begin
                    pc_d = load_addr;                 // T_STAY (load)
                end else if (step_en) begin
                    pc_d[W-1:0] = add_sum;
                    if (add_cout && !addend_neg) begin
                        cc_d    = CC_INC;             // T_NEED_HIGH
                        state_d = ST_HIGH;
                    end else if (!add_cout && addend_neg) begin
                        cc_d    = CC_DEC;             // T_NEED_HIGH
                        state_d = ST_HIGH;
                    end
                end
            end
            ST_HIGH: begin
                state_d = ST_READY;
                cc_d    = CC_NONE;
                if (load_en) begin
                    pc_d = load_addr;                 // T_HIGH_LOAD
                end else begin
                    pc_d[AW-1:W] = add_sum;           // T_HIGH_DONE
                end
            end
        endcase
    end

    // outputs: adder ownership and operands
    always_comb begin
        add_a    = op_a;
        add_b    = op_b;
        add_cin  = 1'b0;
        add_free = 1'b1;
        unique case (state_q)
            ST_READY: begin
                if (step_go) begin
                    add_a    = pc_q[W-1:0];
                    add_b    = addend;
                    add_free = 1'b0;
                end
            end
            ST_HIGH: begin
                add_a    = pc_q[AW-1:W];
                add_b    = (cc_q == CC_DEC) ? '1 : '0;
                add_cin  = (cc_q == CC_INC);
                add_free = 1'b0;
            end
        endcase
        pc   = pc_q;
        busy = (state_q == ST_HIGH);
    end
endmodule

// File: rtl/pc_stepper.sv
module pc_stepper #(
    parameter int BYTE_W = 8,
    localparam int ADDR_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_en,
    input  logic              use_off,
    input  logic              off_signed,
    input  logic [BYTE_W-1:0] offset,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [1:0]        alu_sel,
    input  logic [BYTE_W-1:0] op_a,
    input  logic [BYTE_W-1:0] op_b,
    input  logic              logic_or,
    input  logic              shift_right,
    output logic [ADDR_W-1:0] pc,
    output logic              busy,
    output logic [BYTE_W-1:0] alu_y,
    output logic              alu_co
);
    logic [BYTE_W-1:0] add_a, add_b, add_sum;
    logic              add_cin, add_cout, add_free;

    pcs_adder #(.W(BYTE_W)) u_adder (
        .a(add_a), .b(add_b), .cin(add_cin), .sum(add_sum), .cout(add_cout)
    );

    pcs_pc_fsm #(.W(BYTE_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .use_off(use_off),
        .off_signed(off_signed), .offset(offset), .load_en(load_en),
        .load_addr(load_addr), .op_a(op_a), .op_b(op_b),
        .add_sum(add_sum), .add_cout(add_cout), .add_a(add_a), .add_b(add_b),
        .add_cin(add_cin), .add_free(add_free), .pc(pc), .busy(busy)
    );

    pcs_result_mux #(.W(BYTE_W)) u_mux (
        .sel(alu_sel), .op_a(op_a), .op_b(op_b), .logic_or(logic_or),
        .shift_right(shift_right), .add_sum(add_sum), .add_cout(add_cout),
        .add_free(add_free), .y(alu_y), .co(alu_co)
    );
endmodule

// File: rtl/pcs_checker.sv
module pcs_checker #(
    parameter int BYTE_W = 8,
    localparam int ADDR_W = 2 * BYTE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              step_en,
    input logic              load_en,
    input logic [ADDR_W-1:0] load_addr,
    input logic [1:0]        alu_sel,
    input logic [ADDR_W-1:0] pc,
    input logic              busy,
    input logic [BYTE_W-1:0] alu_y,
    input logic              alu_co
);
    // R5
    busy_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    // R6
    load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (pc == $past(load_addr)) && !busy);

    // R4
    high_pass_low_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !load_en) |=> pc[BYTE_W-1:0] == $past(pc[BYTE_W-1:0]));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !step_en && !load_en) |=> $stable(pc));

    // R8
    add_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && alu_sel == 2'b00) |-> (alu_y == '0 && !alu_co));
endmodule

bind pc_stepper pcs_checker #(.BYTE_W(BYTE_W)) u_pcs_checker (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .load_en(load_en),
    .load_addr(load_addr), .alu_sel(alu_sel), .pc(pc), .busy(busy),
    .alu_y(alu_y), .alu_co(alu_co)
);

// File: tb/test_pc_stepper.sv
`timescale 1ns/1ps
module test_pc_stepper;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_en = 0, use_off = 0, off_signed = 0, load_en = 0;
    logic [7:0]  offset = 0, op_a = 0, op_b = 0;
    logic [15:0] load_addr = 0;
    logic [1:0]  alu_sel = 0;
    logic        logic_or = 0, shift_right = 0;
    logic [15:0] pc;
    logic        busy;
    logic [7:0]  alu_y;
    logic        alu_co;
    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    pc_stepper i_pc_stepper (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .use_off(use_off),
        .off_signed(off_signed), .offset(offset), .load_en(load_en),
        .load_addr(load_addr), .alu_sel(alu_sel), .op_a(op_a), .op_b(op_b),
        .logic_or(logic_or), .shift_right(shift_right), .pc(pc), .busy(busy),
        .alu_y(alu_y), .alu_co(alu_co)
    );

    // start, use_off, signed, offset, final pc, passes
    localparam int NV = 8;
    localparam logic [42:0] VEC [NV] = '{
        {16'h1234, 1'b0, 1'b0, 8'h00, 16'h1235, 1'b0},
        {16'h12FF, 1'b0, 1'b0, 8'h00, 16'h1300, 1'b1},
        {16'hFFFF, 1'b0, 1'b0, 8'h00, 16'h0000, 1'b1},
        {16'h1230, 1'b1, 1'b0, 8'hE0, 16'h1310, 1'b1},
        {16'h1210, 1'b1, 1'b0, 8'hE0, 16'h12F0, 1'b0},
        {16'h1230, 1'b1, 1'b1, 8'hE0, 16'h1210, 1'b0},
        {16'h1210, 1'b1, 1'b1, 8'hE0, 16'h11F0, 1'b1},
        {16'h0000, 1'b1, 1'b1, 8'hFF, 16'hFFFF, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #5;
    endtask

    task automatic do_load(input logic [15:0] a);
        load_en = 1; load_addr = a; tick(); load_en = 0;
    endtask

    initial begin
        #1000000;
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #35;
        check("R1 pc", pc, 16'h0000);
        check("R1 busy", busy, 0);
        rst_n = 1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [42:0] v;
            logic [15:0] st;
            v = VEC[i];
            st = v[42:27];
            do_load(st);
            step_en = 1; use_off = v[26]; off_signed = v[25]; offset = v[24:17];
            tick();
            step_en = 1; // R5: step while busy must be ignored
            if (v[0]) begin
                check("R4 busy", busy, 1);
                check("R4 low first", pc, {st[15:8], v[8:1]});
                tick();
                step_en = 0;
                check("R4 final", pc, v[16:1]);
                check("R5 busy drop", busy, 0);
            end else begin
                step_en = 0;
                check("R3 busy", busy, 0);
                check("R2 R3 final", pc, v[16:1]);
            end
        end

        // R7 hold
        tick(); tick();
        check("R7 hold", pc, 16'hFFFF);

        // R6 load beats step
        step_en = 1; load_en = 1; load_addr = 16'hABCD; tick();
        load_en = 0; step_en = 0;
        check("R6 priority", pc, 16'hABCD);
        check("R6 busy", busy, 0);

        // R6 load during second pass
        do_load(16'h40FF);
        step_en = 1; use_off = 0; tick(); step_en = 0;
        check("R4 enter", busy, 1);
        load_en = 1; load_addr = 16'h5555; tick(); load_en = 0;
        check("R6 override", pc, 16'h5555);
        check("R6 busy clr", busy, 0);

        // R8 add free
        op_a = 8'hF0; op_b = 8'h20; alu_sel = 2'b00; #1;
        check("R8 sum", alu_y, 8'h10);
        check("R8 carry", alu_co, 1);
        // R8 blocked during busy
        do_load(16'h00FF);
        step_en = 1; #1;
        check("R8 blocked step", {alu_co, alu_y}, 9'h000);
        tick(); step_en = 0;
        check("R8 blocked busy", {alu_co, alu_y}, 9'h000);
        tick();
        check("R8 after", alu_y, 8'h10);

        // R9
        op_a = 8'hC3; op_b = 8'h5A;
        alu_sel = 2'b01; logic_or = 0; #1; check("R9 and", alu_y, 8'h42);
        logic_or = 1; #1; check("R9 or", alu_y, 8'hDB);
        alu_sel = 2'b10; shift_right = 0; #1; check("R9 shl", alu_y, 8'h86);
        shift_right = 1; #1; check("R9 shr", alu_y, 8'h61);
        alu_sel = 2'b11; #1; check("R9 passb", alu_y, 8'h5A);
        check("R9 co", alu_co, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule